// File: doc/BRIEF.md
# Flash Command Mode Interpreter

This block decides what a flash-style memory hands back on a read. It watches bus write cycles framed by an active-low chip select and an active-low write enable, decodes the multi-cycle unlock and command sequences carried by them, and keeps track of the current operating mode. The modes are array read, autoselect identification, an embedded program or erase in progress, erase suspend, and an error condition. The block does not run any program or erase algorithm itself. It starts one through a one-cycle start pulse with address and data, then waits for a done or timeout pulse back from the engine.

Reads use a separate address and strobe. The block steers `rd_data` combinationally, in the same cycle, to one of three sources. The first is the external array word. The second is a status word, in which bit 7 reads 1 when no embedded operation is running, bit 6 toggles on every read while busy, and bit 5 flags a timeout. The third is an identification word in autoselect. While an erase is suspended, a per-sector flag vector decides which sectors still answer with status.

A sector is numbered by the top `log2(NSECT)` address bits. Unlock addresses are compared on the low `UNLK_AW` bits. Commands are decoded from the low eight data bits. The unlock pair is 0xAA to 0x555 followed by 0x55 to 0x2AA. The reset command is 0xF0 at any address.

Top module: `flash_cmd_fsm`

## Requirements
- R1: After reset the block is in array read: reads return `array_rdata` unchanged with no command written, `op_start` and `erase_hold` are 0.
- R2: A write cycle spans the cycles where `ce_n` and `we_n` are both sampled low. Its address is the one present on the first such cycle, and its data is the value present on the last such cycle. Exactly one command is taken per cycle.
- R3: The four writes 0xAA@0x555, 0x55@0x2AA, 0xA0@0x555 and then D@A pulse `op_start` for one cycle with `op_erase`=0, `op_addr`=A and `op_data`=D. Reads then return status with bit 7 = 0.
- R4: A wrong address or data value inside a sequence returns to the mode the sequence began in (array read, or erase suspend). Later writes that would only fit the abandoned sequence have no effect.
- R5: The status word is {bit7 ready, bit6 toggle, bit5 timeout, other bits 0}. While an operation is busy, bit 6 changes on each read.
- R6: A `op_done` pulse ends a program, and the very next read returns array data.
- R7: The six writes 0xAA@0x555, 0x55@0x2AA, 0x80@0x555, 0xAA@0x555, 0x55@0x2AA and 0x30@SA start an erase of the sector of SA. This pulses `op_start` with `op_erase`=1 and `op_addr`=SA.
- R8: 0xB0 written to any address during an erase suspends it and raises `erase_hold`. Reads inside the suspended sector then return status with bit 7 = 1 and a steady bit 6. Reads of other sectors return array data.
- R9: A program sequence is accepted while suspended. When it completes, the suspended read rule from R8 applies again.
- R10: 0x30 at any address while suspended resumes the erase and drops `erase_hold`. When the erase completes, the sector flags are cleared and all reads return array data.
- R11: `op_timeout` during an operation enters the error mode, where reads return status with bit 5 = 1 and bit 7 = 0. Only 0xF0 leaves it, and the next read returns array data.
- R12: 0x90 after the unlock pair enters autoselect. There, read address low bits 0 give `MFG_ID`, 1 gives `DEV_ID`, and other values give 0. Only 0xF0 leaves, with array data on the next read.
- R13: Writes during a program in progress, including 0xF0, have no effect on the mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ce_n | input | 1 | Chip select, active low, sampled on clk |
| we_n | input | 1 | Write enable, active low, sampled on clk |
| bus_addr | input | AW | Write cycle address |
| bus_wdata | input | DW | Write cycle data |
| rd_en | input | 1 | Read strobe, one per read |
| rd_addr | input | AW | Read address |
| array_rdata | input | DW | Array word for `rd_addr` |
| rd_data | output | DW | Steered read word |
| op_start | output | 1 | One-cycle start of an embedded operation |
| op_erase | output | 1 | Started operation is an erase (else program) |
| op_addr | output | AW | Address for the started operation |
| op_data | output | DW | Data for a program |
| op_done | input | 1 | Embedded operation finished |
| op_timeout | input | 1 | Embedded operation exceeded its time limit |
| erase_hold | output | 1 | Erase is suspended and must pause |

## Verification
A wrong mode is visible on the first read after the command that caused it. The read returns status, an ID or array data where another source was due, so each sequence is followed by a read. A lost or stuck sector flag shows only during suspend or after the erase ends, which is why the suspended sector and a neighbouring sector are both read in those windows. A corrupted latched address or data surfaces on `op_addr` and `op_data` two cycles after the strobes release. A toggle that fails to advance shows as two equal consecutive busy reads.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

    typedef enum logic [3:0] {
        MD_READ   = 4'd0,
        MD_U1     = 4'd1,
        MD_U2     = 4'd2,
        MD_PGM    = 4'd3,
        MD_E1     = 4'd4,
        MD_E2     = 4'd5,
        MD_E3     = 4'd6,
        MD_BUSY_P = 4'd7,
        MD_BUSY_E = 4'd8,
        MD_SUSP   = 4'd9,
        MD_ASEL   = 4'd10,
        MD_ERR    = 4'd11
    } mode_e;

    localparam logic [7:0] CMD_UNLK_A  = 8'hAA;
    localparam logic [7:0] CMD_UNLK_B  = 8'h55;
    localparam logic [7:0] CMD_PROGRAM = 8'hA0;
    localparam logic [7:0] CMD_ERASE   = 8'h80;
    localparam logic [7:0] CMD_IDENT   = 8'h90;
    localparam logic [7:0] CMD_SECTOR  = 8'h30;
    localparam logic [7:0] CMD_SUSPEND = 8'hB0;
    localparam logic [7:0] CMD_RESUME  = 8'h30;
    localparam logic [7:0] CMD_RESET   = 8'hF0;

    localparam int ST_READY_BIT  = 7;
    localparam int ST_TOGGLE_BIT = 6;
    localparam int ST_TMO_BIT    = 5;

endpackage

// File: rtl/flash_bus_capture.sv
module flash_bus_capture #(
    parameter int AW = 20,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ce_n,
    input  logic          we_n,
    input  logic [AW-1:0] bus_addr,
    input  logic [DW-1:0] bus_wdata,
    output logic          wr_stb,
    output logic [AW-1:0] wr_addr,
    output logic [DW-1:0] wr_data
);

    typedef struct packed {
        logic          act;
        logic          stb;
        logic [AW-1:0] addr;
        logic [DW-1:0] data;
    } cap_t;

    cap_t cap_d, cap_q;
    logic act_now;

    always_comb begin
        act_now   = ~ce_n & ~we_n;
        cap_d     = cap_q;
        cap_d.act = act_now;
        cap_d.stb = 1'b0;
        if (act_now && !cap_q.act) begin
            cap_d.addr = bus_addr;
        end
        if (act_now) begin
            cap_d.data = bus_wdata;
        end
        if (!act_now && cap_q.act) begin
            cap_d.stb = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cap_q <= '0;
        end else begin
            cap_q <= cap_d;
        end
    end

    assign wr_stb  = cap_q.stb;
    assign wr_addr = cap_q.addr;
    assign wr_data = cap_q.data;

endmodule

// File: rtl/flash_cmd_core.sv
module flash_cmd_core
    import flash_cmd_pkg::*;
#(
    parameter int AW      = 20,
    parameter int DW      = 8,
    parameter int NSECT   = 16,
    parameter int UNLK_AW = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_stb,
    input  logic [AW-1:0]    wr_addr,
    input  logic [DW-1:0]    wr_data,
    input  logic             op_done,
    input  logic             op_timeout,
    output mode_e            mode,
    output logic             susp_ctx,
    output logic             tmo_flag,
    output logic [NSECT-1:0] ers_mask,
    output logic             op_start,
    output logic             op_erase,
    output logic [AW-1:0]    op_addr,
    output logic [DW-1:0]    op_data
);

    localparam int SW = $clog2(NSECT);
    localparam logic [UNLK_AW-1:0] ADDR_FIRST  = UNLK_AW'(11'h555);
    localparam logic [UNLK_AW-1:0] ADDR_SECOND = UNLK_AW'(11'h2AA);

    typedef struct packed {
        mode_e            mode;
        logic             susp;
        logic             tmo;
        logic [NSECT-1:0] mask;
        logic             start;
        logic             erase;
        logic [AW-1:0]    addr;
        logic [DW-1:0]    data;
    } core_t;

    core_t core_d, core_q;

    logic          at_first, at_second, unlk_a, unlk_b;
    logic [7:0]    cmd;
    logic [SW-1:0] wr_sect;
    mode_e         home;

    always_comb begin
        cmd       = wr_data[7:0];
        at_first  = (wr_addr[UNLK_AW-1:0] == ADDR_FIRST);
        at_second = (wr_addr[UNLK_AW-1:0] == ADDR_SECOND);
        unlk_a    = at_first  && (cmd == CMD_UNLK_A);
        unlk_b    = at_second && (cmd == CMD_UNLK_B);
        wr_sect   = wr_addr[AW-1 -: SW];
        home      = core_q.susp ? MD_SUSP : MD_READ;

        core_d       = core_q;
        core_d.start = 1'b0;

        unique case (core_q.mode)
            MD_READ: begin
                if (wr_stb && unlk_a) core_d.mode = MD_U1;
            end
            MD_SUSP: begin
                if (wr_stb) begin
                    if (unlk_a) begin
                        core_d.mode = MD_U1;
                    end else if (cmd == CMD_RESUME) begin
                        core_d.mode = MD_BUSY_E;
                        core_d.susp = 1'b0;
                    end
                end
            end
            MD_U1: begin
                if (wr_stb) core_d.mode = unlk_b ? MD_U2 : home;
            end
            MD_U2: begin
                if (wr_stb) begin
                    core_d.mode = home;
                    if (at_first) begin
                        if (cmd == CMD_PROGRAM) begin
                            core_d.mode = MD_PGM;
                        end else if (cmd == CMD_IDENT && !core_q.susp) begin
                            core_d.mode = MD_ASEL;
                        end else if (cmd == CMD_ERASE && !core_q.susp) begin
                            core_d.mode = MD_E1;
                        end
                    end
                end
            end
            MD_PGM: begin
                if (wr_stb) begin
                    core_d.mode  = MD_BUSY_P;
                    core_d.start = 1'b1;
                    core_d.erase = 1'b0;
                    core_d.addr  = wr_addr;
                    core_d.data  = wr_data;
                end
            end
            MD_E1: begin
                if (wr_stb) core_d.mode = unlk_a ? MD_E2 : MD_READ;
            end
            MD_E2: begin
                if (wr_stb) core_d.mode = unlk_b ? MD_E3 : MD_READ;
            end
            MD_E3: begin
                if (wr_stb) begin
                    if (cmd == CMD_SECTOR) begin
                        core_d.mode          = MD_BUSY_E;
                        core_d.mask[wr_sect] = 1'b1;
                        core_d.start         = 1'b1;
                        core_d.erase         = 1'b1;
                        core_d.addr          = wr_addr;
                        core_d.data          = wr_data;
                    end else begin
                        core_d.mode = MD_READ;
                    end
                end
            end
            MD_BUSY_P: begin
                if (op_timeout) begin
                    core_d.mode = MD_ERR;
                    core_d.tmo  = 1'b1;
                end else if (op_done) begin
                    core_d.mode = home;
                end
            end
            MD_BUSY_E: begin
                if (op_timeout) begin
                    core_d.mode = MD_ERR;
                    core_d.tmo  = 1'b1;
                end else if (op_done) begin
                    core_d.mode = MD_READ;
                    core_d.mask = '0;
                end else if (wr_stb && cmd == CMD_SUSPEND) begin
                    core_d.mode = MD_SUSP;
                    core_d.susp = 1'b1;
                end
            end
            MD_ASEL: begin
                if (wr_stb && cmd == CMD_RESET) core_d.mode = MD_READ;
            end
            MD_ERR: begin
                if (wr_stb && cmd == CMD_RESET) begin
                    core_d.mode = MD_READ;
                    core_d.tmo  = 1'b0;
                    core_d.susp = 1'b0;
                    core_d.mask = '0;
                end
            end
            default: core_d.mode = MD_READ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            core_q <= '0;
        end else begin
            core_q <= core_d;
        end
    end

    assign mode     = core_q.mode;
    assign susp_ctx = core_q.susp;
    assign tmo_flag = core_q.tmo;
    assign ers_mask = core_q.mask;
    assign op_start = core_q.start;
    assign op_erase = core_q.erase;
    assign op_addr  = core_q.addr;
    assign op_data  = core_q.data;

endmodule

// File: rtl/flash_read_mux.sv
module flash_read_mux
    import flash_cmd_pkg::*;
#(
    parameter int          AW     = 20,
    parameter int          DW     = 8,
    parameter int          NSECT  = 16,
    parameter logic [7:0]  MFG_ID = 8'h01,
    parameter logic [7:0]  DEV_ID = 8'h7E
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rd_en,
    input  logic [AW-1:0]    rd_addr,
    input  logic [DW-1:0]    array_rdata,
    input  mode_e            mode,
    input  logic             susp_ctx,
    input  logic             tmo_flag,
    input  logic [NSECT-1:0] ers_mask,
    output logic [DW-1:0]    rd_data,
    output logic             toggle
);

    localparam int SW = $clog2(NSECT);

    logic             tog_d, tog_q;
    logic [SW-1:0]    rd_sect;
    logic [NSECT-1:0] sect_hit;
    logic             busy, err;
    logic [DW-1:0]    status;
    logic             rd_addr_unused;

    assign rd_sect        = rd_addr[AW-1 -: SW];
    assign rd_addr_unused = ^rd_addr[AW-SW-1:2];

    for (genvar i = 0; i < NSECT; i++) begin : g_hit
        assign sect_hit[i] = ers_mask[i] && (rd_sect == SW'(i));
    end

    always_comb begin
        busy   = (mode == MD_BUSY_P) || (mode == MD_BUSY_E);
        err    = (mode == MD_ERR);
        status = '0;
        status[ST_READY_BIT]  = ~(busy | err);
        status[ST_TOGGLE_BIT] = tog_q;
        status[ST_TMO_BIT]    = tmo_flag;

        if (mode == MD_ASEL) begin
            unique case (rd_addr[1:0])
                2'd0:    rd_data = DW'(MFG_ID);
                2'd1:    rd_data = DW'(DEV_ID);
                default: rd_data = '0;
            endcase
        end else if (busy || err) begin
            rd_data = status;
        end else if (susp_ctx && (|sect_hit)) begin
            rd_data = status;
        end else begin
            rd_data = array_rdata;
        end

        tog_d = tog_q ^ (rd_en & (busy | err));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tog_q <= 1'b0;
        end else begin
            tog_q <= tog_d;
        end
    end

    assign toggle = tog_q;

endmodule

// File: rtl/flash_cmd_fsm.sv
module flash_cmd_fsm
    import flash_cmd_pkg::*;
#(
    parameter int         AW      = 20,
    parameter int         DW      = 8,
    parameter int         NSECT   = 16,
    parameter int         UNLK_AW = 11,
    parameter logic [7:0] MFG_ID  = 8'h01,
    parameter logic [7:0] DEV_ID  = 8'h7E
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ce_n,
    input  logic          we_n,
    input  logic [AW-1:0] bus_addr,
    input  logic [DW-1:0] bus_wdata,
    input  logic          rd_en,
    input  logic [AW-1:0] rd_addr,
    input  logic [DW-1:0] array_rdata,
    output logic [DW-1:0] rd_data,
    output logic          op_start,
    output logic          op_erase,
    output logic [AW-1:0] op_addr,
    output logic [DW-1:0] op_data,
    input  logic          op_done,
    input  logic          op_timeout,
    output logic          erase_hold
);

    logic             cap_stb;
    logic [AW-1:0]    cap_addr;
    logic [DW-1:0]    cap_data;
    mode_e            core_mode;
    logic             core_susp;
    logic             core_tmo;
    logic [NSECT-1:0] core_mask;
    logic             rd_toggle;

    flash_bus_capture #(.AW(AW), .DW(DW)) u_cap (
        .clk       (clk),
        .rst_n     (rst_n),
        .ce_n      (ce_n),
        .we_n      (we_n),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .wr_stb    (cap_stb),
        .wr_addr   (cap_addr),
        .wr_data   (cap_data)
    );

    flash_cmd_core #(.AW(AW), .DW(DW), .NSECT(NSECT), .UNLK_AW(UNLK_AW)) u_core (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_stb     (cap_stb),
        .wr_addr    (cap_addr),
        .wr_data    (cap_data),
        .op_done    (op_done),
        .op_timeout (op_timeout),
        .mode       (core_mode),
        .susp_ctx   (core_susp),
        .tmo_flag   (core_tmo),
        .ers_mask   (core_mask),
        .op_start   (op_start),
        .op_erase   (op_erase),
        .op_addr    (op_addr),
        .op_data    (op_data)
    );

    flash_read_mux #(.AW(AW), .DW(DW), .NSECT(NSECT), .MFG_ID(MFG_ID), .DEV_ID(DEV_ID)) u_rmux (
        .clk         (clk),
        .rst_n       (rst_n),
        .rd_en       (rd_en),
        .rd_addr     (rd_addr),
        .array_rdata (array_rdata),
        .mode        (core_mode),
        .susp_ctx    (core_susp),
        .tmo_flag    (core_tmo),
        .ers_mask    (core_mask),
        .rd_data     (rd_data),
        .toggle      (rd_toggle)
    );

    assign erase_hold = core_susp;

endmodule

// File: rtl/flash_cmd_sva.sv
module flash_cmd_sva
    import flash_cmd_pkg::*;
#(
    parameter int AW    = 20,
    parameter int DW    = 8,
    parameter int NSECT = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             op_start,
    input logic             op_erase,
    input logic [AW-1:0]    op_addr,
    input logic             op_done,
    input logic             op_timeout,
    input logic             erase_hold,
    input logic             rd_en,
    input logic             wr_stb,
    input logic [DW-1:0]    wr_data,
    input mode_e            mode,
    input logic [NSECT-1:0] ers_mask,
    input logic             toggle
);

    localparam int SW = $clog2(NSECT);

    logic [SW-1:0] start_sect;
    logic          reset_wr;

    assign start_sect = op_addr[AW-1 -: SW];
    assign reset_wr   = wr_stb && (wr_data[7:0] == CMD_RESET);

    a_r3_start_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        op_start |=> !op_start);

    a_r7_sector_flag_set: assert property (@(posedge clk) disable iff (!rst_n)
        (op_start && op_erase) |=> ers_mask[$past(start_sect)]);

    a_r5_toggle_advances: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && (mode == MD_BUSY_P || mode == MD_BUSY_E)) |=> (toggle != $past(toggle)));

    a_r8_hold_in_suspend: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MD_SUSP) |-> erase_hold);

    a_r10_erase_end_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MD_BUSY_E && op_done && !op_timeout) |=> (ers_mask == '0 && mode == MD_READ));

    a_r11_error_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MD_ERR && !reset_wr) |=> (mode == MD_ERR));

    a_r12_ident_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MD_ASEL && !reset_wr) |=> (mode == MD_ASEL));

    a_r13_program_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MD_BUSY_P && !op_done && !op_timeout) |=> (mode == MD_BUSY_P));

endmodule

bind flash_cmd_fsm flash_cmd_sva #(.AW(AW), .DW(DW), .NSECT(NSECT)) u_sva (
    .clk        (clk),
    .rst_n      (rst_n),
    .op_start   (op_start),
    .op_erase   (op_erase),
    .op_addr    (op_addr),
    .op_done    (op_done),
    .op_timeout (op_timeout),
    .erase_hold (erase_hold),
    .rd_en      (rd_en),
    .wr_stb     (cap_stb),
    .wr_data    (cap_data),
    .mode       (core_mode),
    .ers_mask   (core_mask),
    .toggle     (rd_toggle)
);

// File: tb/flash_cmd_fsm_tb.sv
`timescale 1ns/1ps
module flash_cmd_fsm_tb;

    localparam int AW = 20;
    localparam int DW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ce_n = 1'b1, we_n = 1'b1;
    logic [AW-1:0] bus_addr = '0;
    logic [DW-1:0] bus_wdata = '0;
    logic          rd_en = 1'b0;
    logic [AW-1:0] rd_addr = '0;
    logic [DW-1:0] array_rdata;
    logic [DW-1:0] rd_data;
    logic          op_start, op_erase, erase_hold;
    logic [AW-1:0] op_addr;
    logic [DW-1:0] op_data;
    logic          op_done = 1'b0, op_timeout = 1'b0;

    int checks = 0;
    int errors = 0;

    logic          seen_start, seen_after, seen_erase;
    logic [AW-1:0] seen_addr;
    logic [DW-1:0] seen_data;

    always #2.5 clk = ~clk;

    // bench array model: word = low address byte xor 0x3C
    assign array_rdata = rd_addr[7:0] ^ 8'h3C;

    flash_cmd_fsm u_dut (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .rd_en(rd_en), .rd_addr(rd_addr), .array_rdata(array_rdata),
        .rd_data(rd_data), .op_start(op_start), .op_erase(op_erase),
        .op_addr(op_addr), .op_data(op_data), .op_done(op_done),
        .op_timeout(op_timeout), .erase_hold(erase_hold)
    );

    function automatic logic [7:0] arr(input logic [AW-1:0] a);
        return a[7:0] ^ 8'h3C;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic sample_start();
        seen_start = op_start;
        seen_erase = op_erase;
        seen_addr  = op_addr;
        seen_data  = op_data;
        @(negedge clk);
        seen_after = op_start;
    endtask

    task automatic bus_write(input logic [AW-1:0] a, input logic [7:0] d);
        @(negedge clk); ce_n = 1'b0; we_n = 1'b0; bus_addr = a; bus_wdata = 8'hEE;
        @(negedge clk); bus_addr = ~a; bus_wdata = d;
        @(negedge clk); ce_n = 1'b1; we_n = 1'b1; bus_addr = '0; bus_wdata = 8'h00;
        repeat (2) @(negedge clk);
        sample_start();
    endtask

    // write enable falls first, chip select rises first
    task automatic skew_write(input logic [AW-1:0] a, input logic [7:0] d);
        @(negedge clk); we_n = 1'b0; ce_n = 1'b1; bus_addr = 20'h0FFFF; bus_wdata = 8'hEE;
        @(negedge clk); ce_n = 1'b0; bus_addr = a;
        @(negedge clk); bus_addr = 20'h01111; bus_wdata = d;
        @(negedge clk); ce_n = 1'b1; bus_wdata = 8'h99;
        @(negedge clk); we_n = 1'b1;
        @(negedge clk);
        sample_start();
    endtask

    task automatic do_read(input logic [AW-1:0] a, output logic [7:0] v);
        @(negedge clk); rd_en = 1'b1; rd_addr = a;
        #1 v = rd_data;
        @(negedge clk); rd_en = 1'b0;
    endtask

    task automatic pulse_op(input logic tmo);
        @(negedge clk); op_done = ~tmo; op_timeout = tmo;
        @(negedge clk); op_done = 1'b0; op_timeout = 1'b0;
        @(negedge clk);
    endtask

    task automatic unlock_pair();
        bus_write(20'h00555, 8'hAA);
        bus_write(20'h002AA, 8'h55);
    endtask

    localparam logic [1:0] KW = 2'd0, KR = 2'd1, KS = 2'd2, KD = 2'd3;
    localparam int NV = 27;
    // {kind, requirement, address, data, expected}
    localparam logic [41:0] VEC [NV] = '{
        {KR, 4'd1,  20'h00010, 8'h00, 8'h2C},   // R1 array read after reset
        {KW, 4'd3,  20'h00555, 8'hAA, 8'h00},   // R3 program sequence
        {KW, 4'd3,  20'h002AA, 8'h55, 8'h00},
        {KW, 4'd3,  20'h00555, 8'hA0, 8'h00},
        {KW, 4'd3,  20'h01234, 8'h77, 8'h00},
        {KS, 4'd3,  20'h01234, 8'h00, 8'h00},   // R3 busy status
        {KD, 4'd6,  20'h00000, 8'h00, 8'h00},
        {KR, 4'd6,  20'h01234, 8'h00, 8'h08},   // R6 array after done
        {KW, 4'd4,  20'h00555, 8'hAA, 8'h00},   // R4 wrong second address
        {KW, 4'd4,  20'h002AB, 8'h55, 8'h00},
        {KW, 4'd4,  20'h00555, 8'hA0, 8'h00},
        {KW, 4'd4,  20'h01234, 8'h77, 8'h00},
        {KR, 4'd4,  20'h01234, 8'h00, 8'h08},
        {KW, 4'd4,  20'h00555, 8'hAA, 8'h00},   // R4 wrong second data
        {KW, 4'd4,  20'h002AA, 8'h54, 8'h00},
        {KW, 4'd4,  20'h00555, 8'h80, 8'h00},
        {KR, 4'd4,  20'h00000, 8'h00, 8'h3C},
        {KW, 4'd12, 20'h00555, 8'hAA, 8'h00},   // R12 autoselect
        {KW, 4'd12, 20'h002AA, 8'h55, 8'h00},
        {KW, 4'd12, 20'h00555, 8'h90, 8'h00},
        {KR, 4'd12, 20'h00000, 8'h00, 8'h01},
        {KR, 4'd12, 20'h00001, 8'h00, 8'h7E},
        {KR, 4'd12, 20'h00002, 8'h00, 8'h00},
        {KW, 4'd12, 20'h00555, 8'hAA, 8'h00},
        {KR, 4'd12, 20'h00001, 8'h00, 8'h7E},
        {KW, 4'd12, 20'h00000, 8'hF0, 8'h00},
        {KR, 4'd12, 20'h00001, 8'h00, 8'h3D}
    };

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] v, v2;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 op_start idle", op_start, 0);
        chk("R1 erase_hold idle", erase_hold, 0);
        do_read(20'h00777, v);
        chk("R1 array read", v, arr(20'h00777));

        for (int i = 0; i < NV; i++) begin
            logic [1:0]    k;
            logic [3:0]    rq;
            logic [AW-1:0] a;
            logic [7:0]    d, e;
            {k, rq, a, d, e} = VEC[i];
            case (k)
                KW: bus_write(a, d);
                KD: pulse_op(1'b0);
                KR: begin
                    do_read(a, v);
                    chk($sformatf("R%0d vector %0d", rq, i), v, e);
                end
                default: begin
                    do_read(a, v);
                    chk($sformatf("R%0d vector %0d status", rq, i), v & 8'hBF, e);
                end
            endcase
        end

        // R2 / R3: skewed strobes on the program data write
        unlock_pair();
        bus_write(20'h00555, 8'hA0);
        skew_write(20'h0ABCD, 8'h5A);
        chk("R3 start pulse", seen_start, 1);
        chk("R3 start one cycle", seen_after, 0);
        chk("R3 program kind", seen_erase, 0);
        chk("R2 address at later fall", seen_addr, 20'h0ABCD);
        chk("R2 data at earlier rise", seen_data, 8'h5A);
        // R13 writes while programming
        bus_write(20'h00000, 8'hF0);
        bus_write(20'h00555, 8'hAA);
        do_read(20'h0ABCD, v);
        chk("R13 still busy", v & 8'hBF, 8'h00);
        // R5 toggle
        do_read(20'h0ABCD, v);
        do_read(20'h0ABCD, v2);
        chk("R5 bit6 toggles", (v ^ v2) & 8'h40, 8'h40);
        chk("R5 other bits", v2 & 8'hBF, 8'h00);
        pulse_op(1'b0);
        do_read(20'h0ABCD, v);
        chk("R6 array after program", v, arr(20'h0ABCD));

        // R7 sector erase of sector 3
        unlock_pair();
        bus_write(20'h00555, 8'h80);
        unlock_pair();
        bus_write(20'h30100, 8'h30);
        chk("R7 start pulse", seen_start, 1);
        chk("R7 erase kind", seen_erase, 1);
        chk("R7 sector address", seen_addr, 20'h30100);
        do_read(20'h30010, v);
        chk("R7 busy status", v & 8'hBF, 8'h00);

        // R8 suspend
        bus_write(20'h00000, 8'hB0);
        chk("R8 erase_hold", erase_hold, 1);
        do_read(20'h30010, v);
        do_read(20'h30010, v2);
        chk("R8 suspended sector status", v & 8'hBF, 8'h80);
        chk("R8 steady toggle", v2, v);
        do_read(20'h20010, v);
        chk("R8 other sector array", v, arr(20'h20010));

        // R9 program inside suspend
        unlock_pair();
        bus_write(20'h00555, 8'hA0);
        bus_write(20'h20020, 8'h11);
        chk("R9 start pulse", seen_start, 1);
        chk("R9 program kind", seen_erase, 0);
        chk("R9 hold kept", erase_hold, 1);
        do_read(20'h30010, v);
        chk("R9 busy status", v & 8'hBF, 8'h00);
        pulse_op(1'b0);
        do_read(20'h30010, v);
        chk("R9 suspended status again", v & 8'hBF, 8'h80);
        do_read(20'h20020, v);
        chk("R9 array elsewhere", v, arr(20'h20020));

        // R4 aborted sequence during suspend
        bus_write(20'h00555, 8'hAA);
        bus_write(20'h002AB, 8'h55);
        do_read(20'h30010, v);
        chk("R4 back to suspend", v & 8'hBF, 8'h80);
        chk("R4 hold kept", erase_hold, 1);

        // R10 resume and finish
        bus_write(20'h00000, 8'h30);
        chk("R10 hold dropped", erase_hold, 0);
        do_read(20'h10000, v);
        chk("R10 busy after resume", v & 8'hBF, 8'h00);
        pulse_op(1'b0);
        do_read(20'h30010, v);
        chk("R10 sector flag cleared", v, arr(20'h30010));

        // R11 timeout
        unlock_pair();
        bus_write(20'h00555, 8'hA0);
        bus_write(20'h00040, 8'h22);
        pulse_op(1'b1);
        do_read(20'h00040, v);
        chk("R11 timeout status", v & 8'hBF, 8'h20);
        bus_write(20'h00555, 8'hAA);
        do_read(20'h00040, v);
        chk("R11 error kept", v & 8'hBF, 8'h20);
        bus_write(20'h00000, 8'hF0);
        do_read(20'h00040, v);
        chk("R11 reset to array", v, arr(20'h00040));

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule